// File: doc/BRIEF.md
# Free-Running Timer with Compare Outputs

This block is a 16-bit up-counter that runs continuously on a prescaled system clock. Four compare channels watch it. Each channel holds a 16-bit value and raises a sticky flag when the counter reaches that value. The counter wraps from all ones to zero, and that wrap raises a flag of its own.

Compare channel 0 can optionally send the counter back to zero, which makes the timer period programmable. Each pair of channels (0/1 and 2/3) drives output pins in one of two ways. In the unpaired mode, every match on a channel toggles that channel's own pin. In the paired mode, the even channel's match sets the even pin and the odd channel's match clears it, so a single pin carries a waveform whose edges are placed by two registers.

Software reaches the block through a small word-wide register port. One interrupt line combines all enabled flags.

Top module: `cmp_timer`

## Requirements
- R1: After reset the following all read zero: the counter, the prescaler, the control, enable and flag registers, every compare register, every output pin, and `irq`.
- R2: While running (control bit 0 = 1), the counter advances by one every N clocks, with N = 4^(s+1) and s = control bits 3:2 (4, 16, 64, 256). After the control write that sets run (with bit 6 also set, or from a stopped state), the counter reads floor(k/N) + start value k clocks later.
- R3: An advance from 0xFFFF wraps the counter to 0x0000. On the same clock edge it sets flag bit 0, the wrap flag.
- R4: If the counter takes a new value through counting and that value equals compare register i (address 4+i), flag bit 1+i is set one clock later.
- R5: With control bit 1 set, a channel 0 match returns the counter to zero one clock after it reached the compare value. That clear never sets the wrap flag, so the period is C0 advances.
- R6: For a pair whose mode bit is 0, a match on a channel inverts that channel's pin one clock after the counter reaches the value.
- R7: For a pair whose mode bit is 1 (control bit 4 for channels 0/1, bit 5 for channels 2/3), the mode works as follows. An even-channel match drives the even pin high one clock later. An odd-channel match drives it low. When both match together, low wins. The odd pin is held low.
- R8: Flags (address 2) stay set until software writes 1 to that bit, and a write of 0 leaves a flag unchanged. `irq` is high exactly when some flag bit and the same bit of the enable register (address 3) are both 1.
- R9: Clearing control bit 0 freezes the counter. Writing address 1 loads the counter without causing any match. Writing control with bit 6 = 1 zeroes the counter, the prescaler and all pins. Bit 6 is not stored and reads back 0.
- R10: Control (bits 5:0), enable, flags, counter and compare registers read back on `reg_rdata` combinationally from `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: 0 control, 1 counter, 2 flags, 3 enable, 4..7 compare 0..3 |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| cmp_out | output | 4 | Compare-driven pins, one per channel |
| irq | output | 1 | OR of enabled flags |

## Verification
The bench sweeps all four prescale settings and checks the counter at every clock over several periods. A design that divides by the wrong power, or starts counting one clock early, fails at the first boundary. Counting up through 0xFFFF places the wrap flag on the exact edge. A design that flags one clock late fails there, and so does one that raises the wrap flag when clear-on-match returns the counter to zero. In the paired mode, a channel 0 value is rewritten on the fly so that both channels match in the same cycle. A design where the set side wins leaves the pin high. Loading a counter value equal to a compare register must raise no flag, which exposes match logic that compares the raw counter instead of advance events.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam int PRE_W = 8;

  // mask of prescaler bits that must all be one for an advance tick
  function automatic logic [PRE_W-1:0] div_mask(input logic [1:0] sel);
    return PRE_W'((32'd1 << (2 * int'(sel) + 2)) - 32'd1);
  endfunction

  // sticky flag update: set wins over a software clear in the same cycle
  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    return (cur & ~clr) | set;
  endfunction

  // paired pin update: the clearing channel wins a tie
  function automatic logic pair_next(input logic cur, input logic set, input logic clr);
    logic r;
    if (clr)      r = 1'b0;
    else if (set) r = 1'b1;
    else          r = cur;
    return r;
  endfunction
endpackage

// File: rtl/ct_prescaler.sv
module ct_prescaler import cmp_timer_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] sel,
  output logic       tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  assign mask = div_mask(sel);
  assign tick = run && ((pre_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               pre_q <= '0;
    else if (restart || !run) pre_q <= '0;
    else                      pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/ct_counter.sv
module ct_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          soft_clr,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          match_clr,
  output logic [CW-1:0] cnt,
  output logic          fresh,
  output logic          ovf_evt
);
  localparam logic [CW-1:0] TOP = '1;

  assign ovf_evt = tick && (cnt == TOP) && !soft_clr && !load && !match_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      fresh <= 1'b0;
    end else if (soft_clr) begin
      cnt   <= '0;
      fresh <= 1'b0;
    end else if (load) begin
      cnt   <= load_val;
      fresh <= 1'b0;
    end else if (match_clr) begin
      cnt   <= '0;
      fresh <= 1'b1;
    end else if (tick) begin
      cnt   <= cnt + 1'b1;
      fresh <= 1'b1;
    end else begin
      fresh <= 1'b0;
    end
  end
endmodule

// File: rtl/ct_cmp_bank.sv
module ct_cmp_bank import cmp_timer_pkg::*; #(
  parameter int CW  = 16,
  parameter int NCH = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CW-1:0]           cnt,
  input  logic                    fresh,
  input  logic [NCH-1:0][CW-1:0]  cmpv,
  input  logic [NCH/2-1:0]        pair_en,
  input  logic                    out_clr,
  output logic [NCH-1:0]          hit,
  output logic [NCH-1:0]          pin
);
  localparam int NPAIR = NCH / 2;

  for (genvar i = 0; i < NCH; i++) begin : g_hit
    assign hit[i] = fresh && (cnt == cmpv[i]);
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic ev, od;
    logic [1:0] pq;
    assign ev = hit[2*p];
    assign od = hit[2*p+1];
    assign pin[2*p+1:2*p] = pq;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pq <= 2'b00;
      end else if (out_clr) begin
        pq <= 2'b00;
      end else if (pair_en[p]) begin
        pq[0] <= pair_next(pq[0], ev, od);
        pq[1] <= 1'b0;
      end else begin
        pq[0] <= pq[0] ^ ev;
        pq[1] <= pq[1] ^ od;
      end
    end
  end
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer import cmp_timer_pkg::*; #(
  parameter int CW  = 16,
  parameter int NCH = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_we,
  input  logic [$clog2(NCH+4)-1:0]    reg_addr,
  input  logic [CW-1:0]               reg_wdata,
  output logic [CW-1:0]               reg_rdata,
  output logic [NCH-1:0]              cmp_out,
  output logic                        irq
);
  localparam int AW     = $clog2(NCH + 4);
  localparam int NPAIR  = NCH / 2;
  localparam int FW     = NCH + 1;
  localparam int B_RUN  = 0;
  localparam int B_CLRM = 1;
  localparam int B_PSEL = 2;
  localparam int B_PAIR = 4;
  localparam int B_SOFT = B_PAIR + NPAIR;
  localparam int CTRL_W = B_SOFT;

  logic [CTRL_W-1:0]          ctrl_q;
  logic [FW-1:0]              flags;
  logic [FW-1:0]              en_q;
  logic [NCH-1:0][CW-1:0]     cmp_q;

  logic wr_ctrl, wr_cnt, wr_flags, wr_en;
  logic [NCH-1:0] wr_cmp;
  logic soft_clr, load, run, tick, fresh, ovf_evt, match_clr;
  logic [CW-1:0] cnt;
  logic [NCH-1:0] hit;
  logic [FW-1:0] flag_set, flag_clr;
  logic [NPAIR-1:0] pair_en;

  assign wr_ctrl  = reg_we && (reg_addr == AW'(0));
  assign wr_cnt   = reg_we && (reg_addr == AW'(1));
  assign wr_flags = reg_we && (reg_addr == AW'(2));
  assign wr_en    = reg_we && (reg_addr == AW'(3));
  for (genvar i = 0; i < NCH; i++) begin : g_wcmp
    assign wr_cmp[i] = reg_we && (reg_addr == AW'(4 + i));
  end

  assign soft_clr  = wr_ctrl && reg_wdata[B_SOFT];
  assign load      = wr_cnt;
  assign run       = ctrl_q[B_RUN];
  assign pair_en   = ctrl_q[B_PAIR +: NPAIR];
  assign match_clr = ctrl_q[B_CLRM] && hit[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      en_q   <= '0;
      cmp_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= reg_wdata[CTRL_W-1:0];
      if (wr_en)   en_q   <= reg_wdata[FW-1:0];
      for (int i = 0; i < NCH; i++) begin
        if (wr_cmp[i]) cmp_q[i] <= reg_wdata;
      end
    end
  end

  ct_prescaler u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .restart (soft_clr),
    .sel     (ctrl_q[B_PSEL +: 2]),
    .tick    (tick)
  );

  ct_counter #(.CW(CW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .soft_clr  (soft_clr),
    .load      (load),
    .load_val  (reg_wdata),
    .match_clr (match_clr),
    .cnt       (cnt),
    .fresh     (fresh),
    .ovf_evt   (ovf_evt)
  );

  ct_cmp_bank #(.CW(CW), .NCH(NCH)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt     (cnt),
    .fresh   (fresh),
    .cmpv    (cmp_q),
    .pair_en (pair_en),
    .out_clr (soft_clr),
    .hit     (hit),
    .pin     (cmp_out)
  );

  assign flag_set = {hit, ovf_evt};
  assign flag_clr = wr_flags ? reg_wdata[FW-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else begin
      for (int j = 0; j < FW; j++) flags[j] <= flag_next(flags[j], flag_set[j], flag_clr[j]);
    end
  end

  assign irq = |(flags & en_q);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      AW'(0):  reg_rdata[CTRL_W-1:0] = ctrl_q;
      AW'(1):  reg_rdata = cnt;
      AW'(2):  reg_rdata[FW-1:0] = flags;
      AW'(3):  reg_rdata[FW-1:0] = en_q;
      default: begin
        for (int i = 0; i < NCH; i++) begin
          if (reg_addr == AW'(4 + i)) reg_rdata = cmp_q[i];
        end
      end
    endcase
  end
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk #(
  parameter int CW  = 16,
  parameter int NCH = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 run,
  input logic                 tick,
  input logic [CW-1:0]        cnt,
  input logic                 ovf_evt,
  input logic                 match_clr,
  input logic                 soft_clr,
  input logic                 load,
  input logic [NCH-1:0]       hit,
  input logic [NCH:0]         flags,
  input logic [NCH:0]         flag_clr,
  input logic [NCH/2-1:0]     pair_en,
  input logic [NCH-1:0]       cmp_out
);
  assert_wrap_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> flags[0]);

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !soft_clr && !load && !match_clr) |=> cnt == $past(cnt) + CW'(1));

  assert_clear_on_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (match_clr && !soft_clr && !load) |=> cnt == '0);

  assert_no_wrap_on_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    match_clr |-> !ovf_evt);

  assert_stopped_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !soft_clr && !load && !match_clr) |=> $stable(cnt));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assert_hit_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hit[i] |=> flags[i+1]);
  end

  for (genvar j = 0; j <= NCH; j++) begin : g_fl
    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[j] && !flag_clr[j]) |=> flags[j]);
  end

  for (genvar p = 0; p < NCH/2; p++) begin : g_pr
    assert_pair_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_en[p] && hit[2*p] && !hit[2*p+1] && !soft_clr) |=> cmp_out[2*p]);
    assert_pair_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_en[p] && hit[2*p+1]) |=> !cmp_out[2*p]);
    assert_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!pair_en[p] && hit[2*p] && !soft_clr) |=> cmp_out[2*p] != $past(cmp_out[2*p]));
  end
endmodule

bind cmp_timer cmp_timer_chk #(.CW(CW), .NCH(NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run       (run),
  .tick      (tick),
  .cnt       (cnt),
  .ovf_evt   (ovf_evt),
  .match_clr (match_clr),
  .soft_clr  (soft_clr),
  .load      (load),
  .hit       (hit),
  .flags     (flags),
  .flag_clr  (flag_clr),
  .pair_en   (pair_en),
  .cmp_out   (cmp_out)
);

// File: tb/cmp_timer_tb.sv
module cmp_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd1;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [3:0]  cmp_out;
  logic        irq;

  int total = 0;
  int bad = 0;
  int kcur = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cmp_timer u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmp_out(cmp_out), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (k=%0d)", req, act, exp, kcur);
    end
  endtask

  // drive a write off the edge; it lands on the next rising edge
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); kcur++;
    #1; reg_we = 1'b0; reg_addr = 3'd1;
  endtask

  task automatic start(input logic [15:0] d);
    wr(3'd0, d);
    kcur = 0;
  endtask

  task automatic goto_k(input int k);
    while (kcur < k) begin @(posedge clk); kcur++; end
    #1;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    reg_addr = a; #0.5; v = reg_rdata; reg_addr = 3'd1; #0.5;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(posedge clk);
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check("R1 reg reset", v, 0);
    end
    check("R1 pins reset", cmp_out, 0);
    check("R1 irq reset", irq, 0);
    @(negedge clk); rst_n = 1'b1; #1;

    // R2 prescale sweep, soft clear + run start
    for (int s = 0; s < 4; s++) begin
      int n;
      n = 4 << (2 * s);
      start(16'h0041 | 16'(s << 2));
      for (int k = 0; k <= 2 * n + 8 && k < 600; k++) begin
        goto_k(k);
        check("R2 count vs prescale", reg_rdata, 32'(k / n));
      end
    end

    // R3 wrap from 0xFFFF
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'hFFFE);
    wr(3'd2, 16'h001F);
    wr(3'd3, 16'h0001);
    start(16'h0001);
    goto_k(4); check("R3 reach top", reg_rdata, 16'hFFFF);
    goto_k(7); check("R3 no flag before wrap", irq, 0);
    goto_k(8); check("R3 wrap to zero", reg_rdata, 0);
    check("R3 wrap flag same edge", irq, 1);

    // R8 sticky flag, enable gating, write-one-to-clear
    wr(3'd0, 16'h0000);
    goto_k(kcur + 5); check("R8 flag stays", irq, 1);
    wr(3'd2, 16'h0000); check("R8 write zero keeps flag", irq, 1);
    wr(3'd3, 16'h0000); check("R8 enable off masks irq", irq, 0);
    wr(3'd3, 16'h0001); check("R8 enable on shows flag", irq, 1);
    wr(3'd2, 16'h0001); check("R8 write one clears", irq, 0);
    rd(3'd2, v); check("R8 flag bit0 cleared", v[0], 0);

    // R4 / R6 channel 2 flag and toggle
    wr(3'd0, 16'h0040);
    wr(3'd6, 16'd7);
    wr(3'd2, 16'h001F);
    wr(3'd3, 16'h0008);
    start(16'h0041);
    goto_k(28); check("R4 no flag yet", irq, 0);
    check("R6 pin before match", cmp_out[2], 0);
    goto_k(29); check("R4 flag one clock later", irq, 1);
    check("R6 pin toggled", cmp_out[2], 1);

    // R5 clear on channel 0 match, with R6 toggle on ch0
    wr(3'd0, 16'h0040);
    wr(3'd4, 16'd3);
    wr(3'd2, 16'h001F);
    wr(3'd3, 16'h0001);
    start(16'h0043);
    goto_k(12); check("R5 reaches compare", reg_rdata, 3);
    goto_k(13); check("R5 cleared next clock", reg_rdata, 0);
    check("R6 ch0 toggle on", cmp_out[0], 1);
    goto_k(16); check("R5 counts from zero", reg_rdata, 1);
    goto_k(24); check("R5 second period", reg_rdata, 3);
    goto_k(25); check("R5 second clear", reg_rdata, 0);
    check("R6 ch0 toggle off", cmp_out[0], 0);
    goto_k(60); check("R5 no wrap flag on clear", irq, 0);

    // R7 paired mode, tie resolves low
    wr(3'd0, 16'h0040);
    wr(3'd4, 16'd2);
    wr(3'd5, 16'd6);
    start(16'h0051);
    goto_k(8); check("R7 low before set", cmp_out[0], 0);
    goto_k(9); check("R7 even match sets", cmp_out[0], 1);
    check("R7 odd pin held low", cmp_out[1], 0);
    goto_k(12);
    reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = 16'd6;
    @(posedge clk); kcur++; #1; reg_we = 1'b0; reg_addr = 3'd1;
    goto_k(24); check("R7 held high", cmp_out[0], 1);
    goto_k(25); check("R7 tie clears", cmp_out[0], 0);
    check("R7 odd pin still low", cmp_out[1], 0);

    // R9 stop holds, load makes no match, soft clear
    wr(3'd0, 16'h0000);
    rd(3'd1, v);
    goto_k(kcur + 40);
    check("R9 stopped holds", reg_rdata, v);
    wr(3'd5, 16'h1234);
    wr(3'd2, 16'h001F);
    wr(3'd1, 16'h1234);
    check("R9 load value", reg_rdata, 16'h1234);
    goto_k(kcur + 3);
    rd(3'd2, v); check("R9 load raises no flag", v, 0);
    wr(3'd0, 16'h0040);
    check("R9 soft clear zeroes", reg_rdata, 0);
    check("R9 soft clear pins", cmp_out, 0);

    // R10 readback
    wr(3'd7, 16'hA5A5);
    rd(3'd7, v); check("R10 compare readback", v, 16'hA5A5);
    wr(3'd0, 16'h007E);
    rd(3'd0, v); check("R10 control readback", v, 16'h003E);
    wr(3'd3, 16'h0015);
    rd(3'd3, v); check("R10 enable readback", v, 16'h0015);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule